// File: doc/BRIEF.md
# SDRAM Low-Power and Mode-Register Sequencer

This block lives inside an SDRAM controller and makes two scheduling decisions. First, it watches transfer activity and raises a low-power entry request once the bus has been idle for a delay chosen by a two-bit code. Second, it notices when the refresh-array, drive-strength or power-down-exit configuration fields change after the memory has been initialized. It then issues a write request for the extended mode register. That request carries the assembled field word and is completed with a request/acknowledge handshake.

The timing of the mode-register write follows an update policy field. Under the shared-bus policy, the write is issued when a refresh strobe and a pending read or write access are both present in the same cycle. Under the private-bus policy, the write is issued when the controller asks for self-refresh. The self-refresh entry is then held back until the write has been acknowledged. Policy 0 turns automatic updates off.

Two state machines do the work. The idle machine has three states: `LP_BUSY` (a transfer was seen), `LP_WAIT` (idle cycles are being counted) and `LP_SLEEP` (low power is requested). Its transitions are:
- Any state goes to `LP_BUSY` on a transfer.
- `LP_BUSY` and `LP_WAIT` go to `LP_SLEEP` when the idle count passes the selected delay; otherwise they go to `LP_WAIT`.
- `LP_SLEEP` goes to `LP_WAIT` when the code becomes 3.

The update machine has two states, `UPD_IDLE` and `UPD_REQ`. It goes from `UPD_IDLE` to `UPD_REQ` on a policy trigger while an update is pending, and from `UPD_REQ` back to `UPD_IDLE` on acknowledge.

Top module: `sdram_lp_seq`

## Requirements
- R1: While reset is asserted, `lp_req` and `emr_req` are 0 and `emr_data` holds the reset field word 6'b000001 (refresh-array 0, drive 0, exit speed 1).
- R2: With timeout code 0, `lp_req` is 1 after the first clock edge at which `xfer_active` is sampled low.
- R3: With timeout code 1 (or 2), `lp_req` stays 0 through the first 64 (or 128) idle edges and becomes 1 after idle edge 65 (or 129), counted from the last edge with `xfer_active` high.
- R4: With timeout code 3, `lp_req` is never raised, and a raised `lp_req` drops one edge after the code becomes 3.
- R5: An edge with `xfer_active` high clears `lp_req` and restarts the idle count from zero.
- R6: A change of `cfg_pasr`, `cfg_drv` or `cfg_apde` marks an update as pending only when `init_done` is 1 and the policy is 1 or 2. Changes made before initialization never produce a request.
- R7: Under policy 1, a pending update raises `emr_req` one edge after an edge with both `refresh_stb` and `acc_pending` high. Either strobe alone, or `selfref_req`, does not raise it.
- R8: Under policy 2, a pending update raises `emr_req` one edge after an edge with `selfref_req` high, and `refresh_stb`/`acc_pending` do not raise it. `selfref_go` equals `selfref_req` except that it is 0 under policy 2 while an update is pending. It becomes 1 right after the acknowledging edge.
- R9: Under policy 0 (and 3), field changes set no pending update and `emr_req` is never raised. `selfref_go` follows `selfref_req`.
- R10: `emr_data` is {`cfg_pasr`[5:3], `cfg_drv`[2:1], `cfg_apde`[0]}, captured at the edge that raises `emr_req`, and stable while `emr_req` is 1.
- R11: `emr_req` stays 1 until an edge with `emr_ack` high. At that edge the pending flag clears, unless the current fields differ from the word just sent, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_timeout | input | 2 | Idle delay code: 0 none, 1 short, 2 long, 3 never |
| cfg_pasr | input | 3 | Partial-array self-refresh field |
| cfg_drv | input | 2 | Output drive-strength field |
| cfg_apde | input | 1 | Power-down exit speed: 0 fast, 1 slow |
| cfg_upd_policy | input | 2 | Update policy: 0 off, 1 shared bus, 2 private bus |
| init_done | input | 1 | Memory initialization sequence completed |
| xfer_active | input | 1 | A transfer is in progress this cycle |
| acc_pending | input | 1 | A read or write access is waiting |
| refresh_stb | input | 1 | A refresh command is being issued |
| selfref_req | input | 1 | Controller wants to enter self-refresh |
| emr_ack | input | 1 | Extended mode register write accepted |
| lp_req | output | 1 | Low-power entry request |
| emr_req | output | 1 | Extended mode register write request |
| emr_data | output | 6 | Field word carried by the write request |
| selfref_go | output | 1 | Self-refresh entry permitted and requested |

## Verification
A wrong idle count or state shows up at `lp_req` as an edge one or more cycles early or late. The bench sweeps every timeout code cycle by cycle across 140 idle edges, so any off-by-one is caught at the exact edge where it happens. A lost or stuck pending flag shows up as a missing or extra `emr_req` on the first trigger edge afterwards. Under policy 2 it also shows up as a `selfref_go` that is wrong in the same cycle. A corrupted capture register shows up in `emr_data` one edge after the request rises.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;
    typedef enum logic [1:0] {
        TO_NONE  = 2'd0,
        TO_SHORT = 2'd1,
        TO_LONG  = 2'd2,
        TO_NEVER = 2'd3
    } timeout_e;

    typedef enum logic [1:0] {
        UP_OFF     = 2'd0,
        UP_SHARED  = 2'd1,
        UP_PRIVATE = 2'd2,
        UP_RSVD    = 2'd3
    } upd_policy_e;

    typedef enum logic [1:0] {
        LP_BUSY  = 2'd0,
        LP_WAIT  = 2'd1,
        LP_SLEEP = 2'd2
    } lp_state_e;

    typedef enum logic {
        UPD_IDLE = 1'b0,
        UPD_REQ  = 1'b1
    } upd_state_e;
endpackage

// File: rtl/lp_idle_timer.sv
module lp_idle_timer
    import lp_seq_pkg::*;
#(
    parameter int SHORT_IDLE = 64,
    parameter int LONG_IDLE  = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] timeout_code,
    input  logic       xfer_active,
    output logic       lp_req
);
    localparam int CNT_W = $clog2(LONG_IDLE + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LONG_IDLE + 1);

    lp_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc, delay;
    logic             reached;
    timeout_e         code;

    assign code = timeout_e'(timeout_code);

    // Saturating idle-edge count and the delay picked by the code
    always_comb begin
        cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        unique case (code)
            TO_NONE:  delay = '0;
            TO_SHORT: delay = CNT_W'(SHORT_IDLE);
            TO_LONG:  delay = CNT_W'(LONG_IDLE);
            default:  delay = CNT_MAX;
        endcase
        reached = (code != TO_NEVER) && (cnt_inc > delay);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = xfer_active ? '0 : cnt_inc;
        if (xfer_active) begin
            state_d = LP_BUSY;
        end else begin
            unique case (state_q)
                LP_BUSY, LP_WAIT: state_d = reached ? LP_SLEEP : LP_WAIT;
                LP_SLEEP:         state_d = (code == TO_NEVER) ? LP_WAIT : LP_SLEEP;
                default:          state_d = LP_BUSY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LP_BUSY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        lp_req = (state_q == LP_SLEEP);
    end
endmodule

// File: rtl/lp_emr_updater.sv
module lp_emr_updater
    import lp_seq_pkg::*;
#(
    parameter int PASR_W = 3,
    parameter int DRV_W  = 2,
    localparam int EMR_W = PASR_W + DRV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PASR_W-1:0] pasr,
    input  logic [DRV_W-1:0]  drv,
    input  logic              apde,
    input  logic [1:0]        policy,
    input  logic              init_done,
    input  logic              refresh_stb,
    input  logic              acc_pending,
    input  logic              selfref_req,
    input  logic              emr_ack,
    output logic              emr_req,
    output logic [EMR_W-1:0]  emr_data,
    output logic              selfref_go
);
    localparam logic [EMR_W-1:0] FIELD_RST = EMR_W'(1);

    upd_state_e       state_q, state_d;
    upd_policy_e      pol;
    logic [EMR_W-1:0] fields, snap_q, data_q, data_d;
    logic             pending_q, pending_d;
    logic             pol_on, changed, trigger, ack_done, keep;

    assign pol     = upd_policy_e'(policy);
    assign fields  = {pasr, drv, apde};
    assign pol_on  = (pol == UP_SHARED) || (pol == UP_PRIVATE);
    assign changed = init_done && (fields != snap_q);

    // Trigger and pending-flag logic
    always_comb begin
        trigger = pending_q &&
                  (((pol == UP_SHARED) && refresh_stb && acc_pending) ||
                   ((pol == UP_PRIVATE) && selfref_req));
        ack_done  = (state_q == UPD_REQ) && emr_ack;
        keep      = ack_done ? (pol_on && (fields != data_q)) : pending_q;
        pending_d = keep || (pol_on && changed);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        data_d  = data_q;
        unique case (state_q)
            UPD_IDLE: if (trigger) begin
                state_d = UPD_REQ;
                data_d  = fields;
            end
            UPD_REQ:  if (emr_ack) state_d = UPD_IDLE;
            default:  state_d = UPD_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= UPD_IDLE;
            snap_q    <= FIELD_RST;
            data_q    <= FIELD_RST;
            pending_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            snap_q    <= fields;
            data_q    <= data_d;
            pending_q <= pending_d;
        end
    end

    // Outputs
    always_comb begin
        emr_req    = (state_q == UPD_REQ);
        emr_data   = data_q;
        selfref_go = selfref_req && !((pol == UP_PRIVATE) && pending_q);
    end
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq #(
    parameter int SHORT_IDLE = 64,
    parameter int LONG_IDLE  = 128,
    parameter int PASR_W     = 3,
    parameter int DRV_W      = 2,
    localparam int EMR_W     = PASR_W + DRV_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_timeout,
    input  logic [PASR_W-1:0] cfg_pasr,
    input  logic [DRV_W-1:0]  cfg_drv,
    input  logic              cfg_apde,
    input  logic [1:0]        cfg_upd_policy,
    input  logic              init_done,
    input  logic              xfer_active,
    input  logic              acc_pending,
    input  logic              refresh_stb,
    input  logic              selfref_req,
    input  logic              emr_ack,
    output logic              lp_req,
    output logic              emr_req,
    output logic [EMR_W-1:0]  emr_data,
    output logic              selfref_go
);
    lp_idle_timer #(
        .SHORT_IDLE (SHORT_IDLE),
        .LONG_IDLE  (LONG_IDLE)
    ) u_idle (
        .clk          (clk),
        .rst_n        (rst_n),
        .timeout_code (cfg_timeout),
        .xfer_active  (xfer_active),
        .lp_req       (lp_req)
    );

    lp_emr_updater #(
        .PASR_W (PASR_W),
        .DRV_W  (DRV_W)
    ) u_upd (
        .clk         (clk),
        .rst_n       (rst_n),
        .pasr        (cfg_pasr),
        .drv         (cfg_drv),
        .apde        (cfg_apde),
        .policy      (cfg_upd_policy),
        .init_done   (init_done),
        .refresh_stb (refresh_stb),
        .acc_pending (acc_pending),
        .selfref_req (selfref_req),
        .emr_ack     (emr_ack),
        .emr_req     (emr_req),
        .emr_data    (emr_data),
        .selfref_go  (selfref_go)
    );
endmodule

// File: rtl/sdram_lp_seq_checker.sv
module sdram_lp_seq_checker #(
    parameter int EMR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg_timeout,
    input logic [1:0]       cfg_upd_policy,
    input logic             xfer_active,
    input logic             selfref_req,
    input logic             emr_ack,
    input logic             lp_req,
    input logic             emr_req,
    input logic [EMR_W-1:0] emr_data,
    input logic             selfref_go
);
    a_r5_xfer_clears: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_active |=> !lp_req);

    a_r2_immediate_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_timeout == 2'd0 && !xfer_active) |=> lp_req);

    a_r4_never_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_timeout == 2'd3) |=> !lp_req);

    a_r9_policy_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_upd_policy == 2'd0 && !emr_req) |=> !emr_req);

    a_r11_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (emr_req && !emr_ack) |=> emr_req);

    a_r10_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (emr_req && !emr_ack) |=> $stable(emr_data));

    a_r8_selfref_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_upd_policy == 2'd2 && emr_req) |-> !selfref_go);

    a_r8_go_only_asked: assert property (@(posedge clk) disable iff (!rst_n)
        selfref_go |-> selfref_req);
endmodule

bind sdram_lp_seq sdram_lp_seq_checker #(.EMR_W(EMR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_timeout    (cfg_timeout),
    .cfg_upd_policy (cfg_upd_policy),
    .xfer_active    (xfer_active),
    .selfref_req    (selfref_req),
    .emr_ack        (emr_ack),
    .lp_req         (lp_req),
    .emr_req        (emr_req),
    .emr_data       (emr_data),
    .selfref_go     (selfref_go)
);

// File: tb/sdram_lp_seq_test.sv
`timescale 1ns/1ps
module sdram_lp_seq_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_timeout;
    logic [2:0] cfg_pasr;
    logic [1:0] cfg_drv;
    logic       cfg_apde;
    logic [1:0] cfg_upd_policy;
    logic       init_done, xfer_active, acc_pending, refresh_stb, selfref_req, emr_ack;
    logic       lp_req, emr_req, selfref_go;
    logic [5:0] emr_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sdram_lp_seq uut (
        .clk(clk), .rst_n(rst_n), .cfg_timeout(cfg_timeout), .cfg_pasr(cfg_pasr),
        .cfg_drv(cfg_drv), .cfg_apde(cfg_apde), .cfg_upd_policy(cfg_upd_policy),
        .init_done(init_done), .xfer_active(xfer_active), .acc_pending(acc_pending),
        .refresh_stb(refresh_stb), .selfref_req(selfref_req), .emr_ack(emr_ack),
        .lp_req(lp_req), .emr_req(emr_req), .emr_data(emr_data), .selfref_go(selfref_go)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int word(input int p, input int d, input int a);
        return (p << 3) | (d << 1) | a;
    endfunction

    function automatic int idle_delay(input int code);
        return (code == 1) ? 64 : (code == 2) ? 128 : 0;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; cfg_timeout = 0; cfg_pasr = 0; cfg_drv = 0; cfg_apde = 1;
        cfg_upd_policy = 1; init_done = 0; xfer_active = 1; acc_pending = 0;
        refresh_stb = 0; selfref_req = 0; emr_ack = 0;
        repeat (3) step();
        check("R1 lp_req", lp_req, 0);
        check("R1 emr_req", emr_req, 0);
        check("R1 emr_data", emr_data, 1);
        rst_n = 1;

        // Idle sweep over every timeout code
        for (int code = 0; code < 4; code++) begin
            string tag;
            tag = (code == 0) ? "R2" : (code == 3) ? "R4" : "R3";
            cfg_timeout = 2'(code);
            xfer_active = 1;
            step();
            check("R5 cleared by transfer", lp_req, 0);
            xfer_active = 0;
            for (int k = 1; k <= 140; k++) begin
                step();
                check(tag, lp_req, (code != 3 && k > idle_delay(code)) ? 1 : 0);
            end
        end
        cfg_timeout = 0;
        step();
        check("R2 entry after code change", lp_req, 1);
        cfg_timeout = 3;
        step();
        check("R4 drop on code 3", lp_req, 0);

        // R5: a transfer mid-count restarts the count
        cfg_timeout = 1;
        xfer_active = 1; step(); xfer_active = 0;
        repeat (40) step();
        xfer_active = 1; step(); xfer_active = 0;
        repeat (64) step();
        check("R5 restart edge 64", lp_req, 0);
        step();
        check("R5 restart edge 65", lp_req, 1);
        xfer_active = 1;

        // R6: change before init is ignored
        cfg_pasr = 5; step();
        refresh_stb = 1; acc_pending = 1; step();
        check("R6 pre-init change", emr_req, 0);
        refresh_stb = 0; acc_pending = 0;
        init_done = 1; step();
        refresh_stb = 1; acc_pending = 1; step();
        check("R6 no change no update", emr_req, 0);
        refresh_stb = 0; acc_pending = 0;

        // R7: shared-bus policy
        cfg_drv = 2; step();
        refresh_stb = 1; step();
        check("R7 refresh alone", emr_req, 0);
        refresh_stb = 0; acc_pending = 1; step();
        check("R7 access alone", emr_req, 0);
        acc_pending = 0; selfref_req = 1; #1;
        check("R7 selfref_go not held", selfref_go, 1);
        step();
        check("R7 selfref ignored", emr_req, 0);
        selfref_req = 0;
        refresh_stb = 1; acc_pending = 1; step();
        check("R7 trigger", emr_req, 1);
        check("R10 captured word", emr_data, word(5, 2, 1));
        refresh_stb = 0; acc_pending = 0;
        cfg_pasr = 3;
        repeat (3) begin
            step();
            check("R11 request held", emr_req, 1);
            check("R10 word stable", emr_data, word(5, 2, 1));
        end
        emr_ack = 1; step(); emr_ack = 0;
        check("R11 released on ack", emr_req, 0);
        refresh_stb = 1; acc_pending = 1; step();
        check("R11 pending kept for newer fields", emr_req, 1);
        check("R10 newer word", emr_data, word(3, 2, 1));
        refresh_stb = 0; acc_pending = 0;
        emr_ack = 1; step(); emr_ack = 0;
        check("R11 released again", emr_req, 0);
        refresh_stb = 1; acc_pending = 1; step();
        check("R11 pending cleared", emr_req, 0);
        refresh_stb = 0; acc_pending = 0;

        // R8: private-bus policy
        cfg_upd_policy = 2;
        cfg_apde = 0; step();
        selfref_req = 1; #1;
        check("R8 selfref held back", selfref_go, 0);
        step();
        check("R8 trigger on selfref", emr_req, 1);
        check("R8 still held", selfref_go, 0);
        check("R10 private word", emr_data, word(3, 2, 0));
        emr_ack = 1; step(); emr_ack = 0;
        check("R8 request done", emr_req, 0);
        check("R8 selfref released", selfref_go, 1);
        selfref_req = 0;
        cfg_drv = 1; step();
        refresh_stb = 1; acc_pending = 1; step();
        check("R8 refresh ignored", emr_req, 0);
        refresh_stb = 0; acc_pending = 0;
        selfref_req = 1; #1;
        check("R8 held for second change", selfref_go, 0);
        step();
        check("R8 second trigger", emr_req, 1);
        check("R10 second private word", emr_data, word(3, 1, 0));
        emr_ack = 1; step(); emr_ack = 0; selfref_req = 0;

        // R9: updates disabled
        cfg_upd_policy = 0;
        cfg_pasr = 7; step();
        refresh_stb = 1; acc_pending = 1; selfref_req = 1; #1;
        check("R9 selfref passes", selfref_go, 1);
        repeat (3) begin
            step();
            check("R9 no request", emr_req, 0);
        end
        refresh_stb = 0; acc_pending = 0; selfref_req = 0;
        cfg_upd_policy = 1; step();
        refresh_stb = 1; acc_pending = 1; step();
        check("R9 change under policy 0 not pending", emr_req, 0);
        refresh_stb = 0; acc_pending = 0;
        step();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule